// File: doc/BRIEF.md
# Conditional Branch Resolver

This block decides whether a conditional branch is taken and produces the
address execution continues from. Each request brings the five status flags
of the integer core, a 4-bit condition selector, the current program counter
and a 9-bit signed branch displacement. The flags are only read here; this
block never writes them.

The condition decision is combinational and is also brought out as a 32-bit
word holding exactly 0 or 1. A set-on-condition instruction writes that word
to its destination register, so branches and flag-to-register moves share one
decoder. The branch outcome (taken bit and next program counter) leaves
through a one-entry registered output stage. This stage uses a valid/ready
handshake. A request is accepted when `req_valid_i` and `req_ready_o` are both
high. `req_ready_o` is high when the output stage is empty or is being drained
in the same cycle (`res_ready_i` high). While `res_valid_o` is high and
`res_ready_i` is low, the held result does not change and no new request is
accepted.

Top module: `cond_branch_unit`

## Requirements
- R1: `flags_i` bit positions are [0]=zero Z, [1]=sign S, [2]=overflow V, [3]=carry C, [4]=sticky saturation SAT. Selector codes 0x0, 0x1, 0x2 and 0x4 are true when V, C, Z and S are set, respectively.
- R2: The signed conditions are: code 0x6 true when S XOR V (less than), code 0x7 true when (S XOR V) OR Z (less or equal), code 0xE the negation of 0x6, and code 0xF the negation of 0x7.
- R3: The unsigned conditions are: code 0x3 true when C OR Z (lower or same), and code 0xB true when neither C nor Z is set (higher).
- R4: Code 0x5 is always true. Code 0xD is true exactly when SAT is set.
- R5: Codes 0x8, 0x9, 0xA and 0xC are the negations of codes 0x0, 0x1, 0x2 and 0x4.
- R6: `cond_true_o` shows the decision for the current inputs in the same cycle. `setf_word_o` is 32'd1 when the condition holds and 32'd0 when it does not.
- R7: For an accepted request whose condition holds, the result has `res_taken_o`=1 and `res_next_pc_o` = `pc_i` + the 9-bit displacement sign-extended to 32 bits, computed modulo 2^32.
- R8: For an accepted request whose condition fails, the result has `res_taken_o`=0 and `res_next_pc_o` = `pc_i` + 2, computed modulo 2^32.
- R9: An accepted request makes `res_valid_o` high in the next cycle. A held result with `res_ready_i` high and no new request makes `res_valid_o` low in the next cycle.
- R10: While `res_valid_o` is high and `res_ready_i` is low, `req_ready_o` is low and the result outputs stay stable.
- R11: After reset, `res_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flags_i | input | 5 | Status flags {SAT, C, V, S, Z} |
| cond_sel_i | input | 4 | Condition selector |
| pc_i | input | 32 | Current program counter |
| disp_i | input | 9 | Signed branch displacement |
| req_valid_i | input | 1 | Branch request valid |
| req_ready_o | output | 1 | Request can be accepted |
| cond_true_o | output | 1 | Combinational condition decision |
| setf_word_o | output | 32 | 0-or-1 word for set-on-condition |
| res_valid_o | output | 1 | Registered result valid |
| res_ready_i | input | 1 | Consumer accepts result |
| res_taken_o | output | 1 | Branch taken |
| res_next_pc_o | output | 32 | Next program counter |

## Verification
Two functions can be active in one cycle: the combinational set-on-condition decision for the inputs now on the pins, and the registered branch result from an earlier request, which back-pressure can keep on the outputs. The bench provokes this by holding `res_ready_i` low for several cycles while it keeps changing the selector, flags, PC and displacement with `req_valid_i` high. On every clock it checks that `cond_true_o` and `setf_word_o` follow the new inputs, while the held result and `req_ready_o` match a behavioural model that stalled on the earlier request. The main sweep covers all 16 selectors against all 32 flag combinations.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int FLAG_W = 5;
  localparam int SEL_W  = 4;

  typedef struct packed {
    logic sat;
    logic c;
    logic v;
    logic s;
    logic z;
  } cbu_flags_t;

  typedef enum logic [SEL_W-1:0] {
    CC_OVF   = 4'h0,
    CC_CRY   = 4'h1,
    CC_ZER   = 4'h2,
    CC_ULE   = 4'h3,
    CC_NEG   = 4'h4,
    CC_ALW   = 4'h5,
    CC_SLT   = 4'h6,
    CC_SLE   = 4'h7,
    CC_NOVF  = 4'h8,
    CC_NCRY  = 4'h9,
    CC_NZER  = 4'hA,
    CC_UGT   = 4'hB,
    CC_POS   = 4'hC,
    CC_SATD  = 4'hD,
    CC_SGE   = 4'hE,
    CC_SGT   = 4'hF
  } cbu_cond_e;
endpackage

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
  import cbu_pkg::*;
(
  input  cbu_flags_t        flags,
  input  logic [SEL_W-1:0]  sel,
  output logic              hit
);
  localparam int NBASE = 2 ** (SEL_W - 1);
  localparam logic [SEL_W-2:0] SAT_SLOT = 3'd5;

  logic [NBASE-1:0] base;
  logic             slt;

  // Lower half of the code space holds the plain terms; upper half negates
  // them, except the "always" slot which is reused for the saturation test.
  always_comb begin
    slt     = flags.s ^ flags.v;
    base    = '0;
    base[0] = flags.v;
    base[1] = flags.c;
    base[2] = flags.z;
    base[3] = flags.c | flags.z;
    base[4] = flags.s;
    base[5] = 1'b1;
    base[6] = slt;
    base[7] = slt | flags.z;
  end

  logic [SEL_W-2:0] idx;
  logic             pick;

  always_comb begin
    idx  = sel[SEL_W-2:0];
    pick = base[idx];
    if (!sel[SEL_W-1])
      hit = pick;
    else if (idx == SAT_SLOT)
      hit = flags.sat;
    else
      hit = ~pick;
  end
endmodule

// File: rtl/cbu_target_calc.sv
module cbu_target_calc #(
  parameter int XLEN    = 32,
  parameter int DISP_W  = 9,
  parameter int PC_STEP = 2
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              taken,
  output logic [XLEN-1:0]   next_pc
);
  localparam int EXT_W = XLEN - DISP_W;

  logic [XLEN-1:0] disp_ext;
  logic [XLEN-1:0] jump_pc;
  logic [XLEN-1:0] seq_pc;

  always_comb begin
    disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    jump_pc  = pc + disp_ext;
    seq_pc   = pc + XLEN'(PC_STEP);
    next_pc  = taken ? jump_pc : seq_pc;
  end
endmodule

// File: rtl/cbu_result_stage.sv
module cbu_result_stage #(
  parameter int WIDTH = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  logic             full_q;
  logic [WIDTH-1:0] data_q;
  logic             load;

  always_comb begin
    in_ready = ~full_q | out_ready;
    load     = in_valid & in_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (load) begin
      full_q <= 1'b1;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) data_q <= in_data;
  end

  assign out_valid = full_q;
  assign out_data  = data_q;
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cbu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int DISP_W  = 9,
  parameter int PC_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        flags_i,
  input  logic [3:0]        cond_sel_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  output logic              cond_true_o,
  output logic [XLEN-1:0]   setf_word_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic              res_taken_o,
  output logic [XLEN-1:0]   res_next_pc_o
);
  localparam int PAY_W = XLEN + 1;

  cbu_flags_t      flags;
  logic            hit;
  logic [XLEN-1:0] next_pc;
  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;

  assign flags = cbu_flags_t'(flags_i);

  cbu_cond_eval u_eval (
    .flags (flags),
    .sel   (cond_sel_i),
    .hit   (hit)
  );

  cbu_target_calc #(
    .XLEN    (XLEN),
    .DISP_W  (DISP_W),
    .PC_STEP (PC_STEP)
  ) u_target (
    .pc      (pc_i),
    .disp    (disp_i),
    .taken   (hit),
    .next_pc (next_pc)
  );

  assign pay_in = {hit, next_pc};

  cbu_result_stage #(
    .WIDTH (PAY_W)
  ) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid_i),
    .in_ready  (req_ready_o),
    .in_data   (pay_in),
    .out_valid (res_valid_o),
    .out_ready (res_ready_i),
    .out_data  (pay_out)
  );

  assign cond_true_o   = hit;
  assign setf_word_o   = {{(XLEN-1){1'b0}}, hit};
  assign res_taken_o   = pay_out[PAY_W-1];
  assign res_next_pc_o = pay_out[XLEN-1:0];
endmodule

// File: rtl/cbu_checker.sv
module cbu_checker #(
  parameter int XLEN    = 32,
  parameter int DISP_W  = 9,
  parameter int PC_STEP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        flags_i,
  input logic [3:0]        cond_sel_i,
  input logic [XLEN-1:0]   pc_i,
  input logic [DISP_W-1:0] disp_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              cond_true_o,
  input logic [XLEN-1:0]   setf_word_o,
  input logic              res_valid_o,
  input logic              res_ready_i,
  input logic              res_taken_o,
  input logic [XLEN-1:0]   res_next_pc_o
);
  logic acc;
  assign acc = req_valid_i & req_ready_o;

  p_zero_cond_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel_i == 4'h2) |-> (cond_true_o == flags_i[0]));

  p_signed_lt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel_i == 4'h6) |-> (cond_true_o == (flags_i[1] ^ flags_i[2])));

  p_unsigned_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel_i == 4'hB) |-> (cond_true_o == ~(flags_i[3] | flags_i[0])));

  p_always_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel_i == 4'h5) |-> cond_true_o);

  p_not_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel_i == 4'h9) |-> (cond_true_o == ~flags_i[3]));

  p_setf_binary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (setf_word_o[XLEN-1:1] == '0) && (setf_word_o[0] == cond_true_o));

  p_taken_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cond_true_o) |=> (res_taken_o &&
      res_next_pc_o == $past(pc_i) +
        {{(XLEN-DISP_W){$past(disp_i[DISP_W-1])}}, $past(disp_i)}));

  p_seq_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cond_true_o) |=> (!res_taken_o &&
      res_next_pc_o == $past(pc_i) + XLEN'(PC_STEP)));

  p_valid_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> res_valid_o);

  p_stall_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |-> !req_ready_o);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(res_taken_o) && $stable(res_next_pc_o)));
endmodule

bind cond_branch_unit cbu_checker #(
  .XLEN    (XLEN),
  .DISP_W  (DISP_W),
  .PC_STEP (PC_STEP)
) u_cbu_checker (.*);

// File: tb/cond_branch_unit_tb.sv
`timescale 1ns/1ps
module cond_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  flags_i = '0;
  logic [3:0]  cond_sel_i = '0;
  logic [31:0] pc_i = '0;
  logic [8:0]  disp_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        cond_true_o;
  logic [31:0] setf_word_o;
  logic        res_valid_o;
  logic        res_ready_i = 1'b1;
  logic        res_taken_o;
  logic [31:0] res_next_pc_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cond_branch_unit dut_i (.*);

  // Behavioural decision written from the requirement table.
  function automatic bit ref_cond(input logic [3:0] sel, input logic [4:0] f);
    bit z, s, v, c, sat;
    z = f[0]; s = f[1]; v = f[2]; c = f[3]; sat = f[4];
    case (sel)
      4'h0: return v;                          // R1
      4'h1: return c;                          // R1
      4'h2: return z;                          // R1
      4'h3: return c || z;                     // R3
      4'h4: return s;                          // R1
      4'h5: return 1;                          // R4
      4'h6: return s != v;                     // R2
      4'h7: return (s != v) || z;              // R2
      4'h8: return !v;                         // R5
      4'h9: return !c;                         // R5
      4'hA: return !z;                         // R5
      4'hB: return !c && !z;                   // R3
      4'hC: return !s;                         // R5
      4'hD: return sat;                        // R4
      4'hE: return s == v;                     // R2
      default: return !((s != v) || z);        // R2
    endcase
  endfunction

  // Cycle model of the output stage.
  bit        m_valid = 0;
  bit        m_taken = 0;
  bit [31:0] m_pc = '0;

  always @(posedge clk) begin
    bit acc;
    bit t;
    if (!rst_n) begin
      m_valid <= 0;
    end else begin
      acc = req_valid_i && (!m_valid || res_ready_i);
      if (acc) begin
        t = ref_cond(cond_sel_i, flags_i);
        m_valid <= 1;
        m_taken <= t;
        m_pc <= t ? pc_i + {{23{disp_i[8]}}, disp_i} : pc_i + 32'd2;
      end else if (res_ready_i) begin
        m_valid <= 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Compare every clock, 1 ns after the negedge where inputs are driven.
  always @(negedge clk) begin
    bit e;
    #1;
    if (rst_n && !done) begin
      e = ref_cond(cond_sel_i, flags_i);
      chk(cond_true_o == e, "R1/R2/R3/R4/R5", "cond_true", 32'(cond_true_o), 32'(e));
      chk(setf_word_o == 32'(e), "R6", "setf_word", setf_word_o, 32'(e));
      chk(res_valid_o == m_valid, "R9", "res_valid", 32'(res_valid_o), 32'(m_valid));
      chk(req_ready_o == (!m_valid || res_ready_i), "R10", "req_ready",
          32'(req_ready_o), 32'(!m_valid || res_ready_i));
      if (m_valid) begin
        chk(res_taken_o == m_taken, "R7/R8", "res_taken", 32'(res_taken_o), 32'(m_taken));
        chk(res_next_pc_o == m_pc, m_taken ? "R7" : "R8", "res_next_pc",
            res_next_pc_o, m_pc);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(res_valid_o == 1'b0, "R11", "reset res_valid", 32'(res_valid_o), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // Sweep all selectors against all flag combinations (R1..R9).
    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 32; f++) begin
        @(negedge clk);
        cond_sel_i  = 4'(s);
        flags_i     = 5'(f);
        pc_i        = 32'h1000_0000 + 32'(s * 512 + f * 6);
        disp_i      = 9'((s * 37 + f * 11) & 9'h1FF);
        req_valid_i = (f % 3) != 2;
        res_ready_i = 1'b1;
      end
    end
    // Displacement and wrap boundaries (R7, R8).
    @(negedge clk); cond_sel_i = 4'h5; pc_i = 32'hFFFF_FFFE; disp_i = 9'h0FF; req_valid_i = 1;
    @(negedge clk); cond_sel_i = 4'h5; pc_i = 32'h0000_0010; disp_i = 9'h100;
    @(negedge clk); cond_sel_i = 4'h2; flags_i = 5'h00; pc_i = 32'hFFFF_FFFF;
    // Back-pressure with changing inputs (R10, R6).
    @(negedge clk); res_ready_i = 0; cond_sel_i = 4'h7; flags_i = 5'h02; pc_i = 32'h2000;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cond_sel_i = 4'(k * 3 + 1);
      flags_i    = 5'(k * 7);
      pc_i       = 32'h3000 + 32'(k * 4);
      disp_i     = 9'(k * 45);
    end
    @(negedge clk); res_ready_i = 1; req_valid_i = 1; cond_sel_i = 4'hD; flags_i = 5'h10;
    @(negedge clk); req_valid_i = 0;
    // Drain without a new request (R9).
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule